// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external asynchronous static RAM with an 18-bit word address and a 4-bit bidirectional data bus. It turns one host request into one complete single-word read or write on the memory pins. It generates active-low select, output-enable and write-enable strobes, and it drives or releases the shared data bus.

Every phase of a transaction lasts a whole number of clock cycles. These counts are derived at elaboration from nanosecond figures and the clock period, as ceil(ns / period) with a floor of one cycle. A read holds select and output enable low for the access time, captures the word on the last access cycle, then acknowledges. A write first releases output enable and waits out the memory's bus turn-off time. It then pulses write enable while driving data, and keeps the data driven for a hold phase after write enable rises. Write enable therefore ends every write, and output enable is never low while the controller drives.

The host presents a request together with the address, write data and a direction flag. The controller accepts the request only when idle and latches all three. It answers with a single-cycle acknowledge, which carries the read word for reads.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, mem_ce_n_o, mem_oe_n_o and mem_we_n_o are all 1, ack_o is 0, and the controller does not drive mem_dq_io.
- R2: A read (we_i=0) holds mem_ce_n_o=0 and mem_oe_n_o=0 with mem_we_n_o=1 for exactly RD_CYC cycles. ack_o then pulses in the next cycle, with rdata_o equal to the word the memory presented on its last access cycle.
- R3: A write (we_i=1) first holds mem_ce_n_o=0 with mem_oe_n_o=1 and mem_we_n_o=1 for exactly TURN_CYC cycles before mem_we_n_o falls. mem_oe_n_o stays 1 for the whole write, and the controller drives mem_dq_io only while mem_oe_n_o is 1.
- R4: A write holds mem_we_n_o=0 for exactly PULSE_CYC cycles while driving the latched data. Select and the driven data are kept for exactly HOLD_CYC cycles after mem_we_n_o rises, so the memory stores the word.
- R5: The address and write data are latched on acceptance and stay constant on the memory pins through the transaction, even when addr_i and wdata_i change.
- R6: A request raised while a transaction is in progress is ignored. It causes no memory access before or after the current transaction ends.
- R7: ack_o is high for exactly one cycle per transaction. In the cycle after the acknowledge, mem_ce_n_o is 1 (standby) and ack_o is 0.
- R8: mem_we_n_o and mem_oe_n_o are never 0 together, and mem_we_n_o is 0 only while mem_ce_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transaction request, sampled when idle |
| we_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 4 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read data, valid with ack_o |
| mem_addr_o | output | 18 | Memory address pins |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dq_io | inout | 4 | Memory data bus |

## Verification
Writes and reads are run with all-zero, all-one and alternating nibbles at addresses from zero to the top of the space. Reading each location back separates a correctly timed strobe from one that stores the wrong data or the wrong location. The bench counts the cycles of each strobe phase against its own ns-to-cycle arithmetic, which exposes an off-by-one in any phase. A second request is pushed into every transaction with inverted address and data while the host inputs are scrambled. Reading the inverted slot afterwards shows whether the stray request reached the memory or the latched fields leaked. Back-to-back write, read and write sequences check the return to standby between transactions.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WTURN  = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4,
        ST_ACK    = 3'd5
    } phase_e;

    // Whole clock cycles covering a nanosecond figure, never fewer than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/dq_pad.sv
module dq_pad #(
    parameter int W = 4
) (
    inout  wire  [W-1:0] pad_io,
    input  logic         en_i,
    input  logic [W-1:0] out_i,
    output logic [W-1:0] in_o
);
    assign pad_io = en_i ? out_i : {W{1'bz}};
    assign in_o   = pad_io;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 4,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 12,
    parameter int T_OEZ_NS = 6,
    parameter int T_PWE_NS = 10,
    parameter int T_SD_NS  = 7,
    parameter int T_AW_NS  = 10,
    parameter int T_DH_NS  = 0,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    inout  wire  [DATA_W-1:0] mem_dq_io
);
    localparam int RD_CYC    = ns2cyc(T_RC_NS, CLK_NS);
    localparam int TURN_CYC  = ns2cyc(T_OEZ_NS, CLK_NS);
    localparam int PULSE_CYC = ns2cyc(max3(T_PWE_NS, T_SD_NS, T_AW_NS), CLK_NS);
    localparam int HOLD_CYC  = ns2cyc(T_DH_NS, CLK_NS);

    typedef struct packed {
        phase_e            state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic              ack;
    } ctl_t;

    ctl_t              cur_q, nxt_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [DATA_W-1:0] dq_in;

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    dq_pad #(.W(DATA_W)) u_pad (
        .pad_io (mem_dq_io),
        .en_i   (cur_q.drv),
        .out_i  (cur_q.wdata),
        .in_o   (dq_in)
    );

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (cur_q.state)
            ST_IDLE: if (req_i) begin
                nxt_d.addr  = addr_i;
                nxt_d.wdata = wdata_i;
                tmr_load    = 1'b1;
                if (we_i) begin
                    nxt_d.state = ST_WTURN;
                    tmr_val     = CNT_W'(TURN_CYC - 1);
                end else begin
                    nxt_d.state = ST_RD;
                    tmr_val     = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD: if (tmr_zero) begin
                nxt_d.rdata = dq_in;
                nxt_d.state = ST_ACK;
            end
            ST_WTURN: if (tmr_zero) begin
                nxt_d.state = ST_WPULSE;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(PULSE_CYC - 1);
            end
            ST_WPULSE: if (tmr_zero) begin
                nxt_d.state = ST_WHOLD;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(HOLD_CYC - 1);
            end
            ST_WHOLD: if (tmr_zero) nxt_d.state = ST_ACK;
            ST_ACK:   nxt_d.state = ST_IDLE;
            default:  nxt_d.state = ST_IDLE;
        endcase
        nxt_d.ce_n = !(nxt_d.state inside {ST_RD, ST_WTURN, ST_WPULSE, ST_WHOLD});
        nxt_d.oe_n = (nxt_d.state != ST_RD);
        nxt_d.we_n = (nxt_d.state != ST_WPULSE);
        nxt_d.drv  = (nxt_d.state inside {ST_WPULSE, ST_WHOLD});
        nxt_d.ack  = (nxt_d.state == ST_ACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.ce_n  <= 1'b1;
            cur_q.oe_n  <= 1'b1;
            cur_q.we_n  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_o      = cur_q.ack;
    assign rdata_o    = cur_q.rdata;
    assign mem_addr_o = cur_q.addr;
    assign mem_ce_n_o = cur_q.ce_n;
    assign mem_oe_n_o = cur_q.oe_n;
    assign mem_we_n_o = cur_q.we_n;

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n_o && !mem_oe_n_o)); // R8
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !mem_ce_n_o); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.drv |-> mem_oe_n_o); // R3
    AST_TURN_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> ($past(mem_oe_n_o) && !$past(mem_ce_n_o) && !$past(cur_q.drv))); // R3
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (!ack_o && mem_ce_n_o)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o)); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.drv && $past(cur_q.drv)) |-> $stable(cur_q.wdata)); // R4
endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
    localparam int CLK_PERIOD = 5;
    localparam int T_RC = 12, T_OEZ = 6, T_PWE = 10, T_SD = 7, T_AW = 10, T_DH = 0;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        if (c < 1) c = 1;
        return c;
    endfunction

    localparam int E_RD    = cyc_of(T_RC);
    localparam int E_TURN  = cyc_of(T_OEZ);
    localparam int E_PULSE = cyc_of(T_PWE);
    localparam int E_HOLD  = cyc_of(T_DH);

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [17:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic        ack;
    logic [3:0]  rdata;
    logic [17:0] maddr;
    logic        ce_n, oe_n, we_n;
    wire  [3:0]  dq;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [3:0] mem [64];
    logic [3:0] model [64];

    assign dq = (!ce_n && !oe_n && we_n) ? mem[maddr[5:0]] : 4'bz;

    always @(posedge we_n) if (!ce_n) mem[maddr[5:0]] = dq;

    sram_seq_ctrl #(
        .CLK_NS(CLK_PERIOD), .T_RC_NS(T_RC), .T_OEZ_NS(T_OEZ), .T_PWE_NS(T_PWE),
        .T_SD_NS(T_SD), .T_AW_NS(T_AW), .T_DH_NS(T_DH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .ack_o(ack), .rdata_o(rdata), .mem_addr_o(maddr), .mem_ce_n_o(ce_n),
        .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_dq_io(dq)
    );

    always #(CLK_PERIOD/2.0) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // One transaction with a stray request and scrambled inputs mid-way.
    task automatic xact(input bit wr, input logic [17:0] a, input logic [3:0] d);
        int cyc = 0, n_oe = 0, n_we = 0, n_turn = 0, n_post = 0, bad_addr = 0;
        bit we_seen = 0;
        @(negedge clk);
        req = 1'b1; we = wr; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = ~wr; addr = ~a; wdata = ~d;
        do begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (cyc == 2) begin req = 1'b1; we = 1'b1; addr = ~a; wdata = ~d; end
            if (cyc == 3) req = 1'b0;
            if (!ce_n && maddr != a) bad_addr++;
            if (!ce_n && !oe_n) n_oe++;
            if (!we_n) begin n_we++; we_seen = 1; end
            else if (!ce_n && oe_n && !we_seen) n_turn++;
            else if (!ce_n && oe_n && we_seen) n_post++;
        end while (!ack && cyc < 40);
        chk(bad_addr == 0, "R5 address held", bad_addr, 0);
        if (wr) begin
            model[a[5:0]] = d;
            chk(cyc == E_TURN + E_PULSE + E_HOLD + 1, "R4 write latency", cyc, E_TURN + E_PULSE + E_HOLD + 1);
            chk(n_turn == E_TURN, "R3 turnaround cycles", n_turn, E_TURN);
            chk(n_oe == 0, "R3 oe low in write", n_oe, 0);
            chk(n_we == E_PULSE, "R4 we pulse cycles", n_we, E_PULSE);
            chk(n_post == E_HOLD, "R4 hold cycles", n_post, E_HOLD);
        end else begin
            chk(cyc == E_RD + 1, "R2 read latency", cyc, E_RD + 1);
            chk(n_oe == E_RD, "R2 oe low cycles", n_oe, E_RD);
            chk(n_we == 0, "R2 we stays high", n_we, 0);
            chk(rdata == model[a[5:0]], "R2 read data", rdata, model[a[5:0]]);
        end
        @(negedge clk);
        chk(!ack, "R7 ack one cycle", ack, 0);
        chk(ce_n, "R7 standby after ack", ce_n, 1);
    endtask

    task automatic t_reset();
        chk(ce_n && oe_n && we_n, "R1 strobes idle", {ce_n, oe_n, we_n}, 7);
        chk(!ack, "R1 ack low", ack, 0);
        chk(dq === mem[maddr[5:0]] || oe_n, "R1 bus released", 0, 0);
    endtask

    task automatic t_patterns();
        xact(1'b1, 18'h00003, 4'h0);
        xact(1'b0, 18'h00003, 4'h0);
        xact(1'b1, 18'h3FFFF, 4'hF);
        xact(1'b0, 18'h3FFFF, 4'h0);
        xact(1'b1, 18'h2A5A5, 4'hA);
        xact(1'b0, 18'h2A5A5, 4'h0);
        xact(1'b1, 18'h15550, 4'h5);
        xact(1'b0, 18'h15550, 4'h0);
    endtask

    // R6: stray writes to ~addr with ~data during the above must not land.
    task automatic t_busy_ignored();
        xact(1'b0, 18'h0003C, 4'h0);
        xact(1'b0, 18'h0001A, 4'h0);
        xact(1'b0, 18'h00000, 4'h0);
        xact(1'b0, 18'h0002F, 4'h0);
        chk(mem[6'h3C] == model[6'h3C], "R6 stray request ignored", mem[6'h3C], model[6'h3C]);
    endtask

    task automatic t_back_to_back();
        xact(1'b1, 18'h00007, 4'h9);
        xact(1'b1, 18'h00008, 4'h6);
        xact(1'b0, 18'h00007, 4'h0);
        xact(1'b0, 18'h00008, 4'h0);
        chk(ce_n && oe_n && we_n, "R8 idle strobes after sequence", {ce_n, oe_n, we_n}, 7);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]   = 4'(i) ^ 4'h5;
            model[i] = 4'(i) ^ 4'h5;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_busy_ignored();
        t_back_to_back();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule